// File: doc/BRIEF.md
# Power-Device On-Time and Duty Guard

This block watches the control signal that switches a power device and raises a latched trip when the device is stressed too hard. It guards two conditions. The first is a single on-interval that lasts too long, which means too much heat at once. The second is a long-run ratio of on-time to off-time that is too high, which means too much heat on average. Both are caught by one saturating up/down counter. The counter steps up on each prescaled tick while the control is high and steps down on each tick while it is low. A step up that would pass the counter's ceiling sets the trip, and the trip output can drive a relay.

The prescale input sets the tick period to `presc_i + 1` clock cycles. The counter has `CNT_W` bits, so the longest on-interval allowed from an empty counter is about `(presc_i+1) * 2^CNT_W / UP_STEP` cycles. The ratio `DN_STEP : UP_STEP` sets the highest sustained on:off ratio that never trips. By default it is 1:1.

Once the count has drained to zero with the control low, the guard goes idle. The counter and the prescaler are held until the next rising edge of the control signal. That edge restarts the prescaler phase from zero, so every on-interval is measured from its own start.

Top module: `pwr_guard`

## Requirements
- R1: While reset is applied, and right after it, `count_o` is 0, `zero_o` is 1 and `trip_o` is 0.
- R2: On each tick while `on_i` is 1, the count rises by `UP_STEP`. The clock edge that sees `on_i` rise counts as an active edge of the prescaler.
- R3: On each tick while `on_i` is 0, the count falls by `DN_STEP`. It stops at 0 and never goes below it.
- R4: The count saturates at its all-ones value (15 for `CNT_W`=4). It never wraps.
- R5: An up step that would take the count above all-ones sets `trip_o` one cycle later. `trip_o` then stays 1 whatever `on_i` does, until reset.
- R6: `zero_o` is 1 exactly when `count_o` is 0.
- R7: While the guard is active, ticks occur every `presc_i + 1` clock cycles. With `presc_i` = 3 the first up step appears after the 4th edge that sees `on_i` high.
- R8: When a down step brings the count to 0, the guard goes idle. The count and the prescaler are held until a rising edge of `on_i`, and that edge restarts the prescaler phase from zero.
- R9: With `UP_STEP`=1 and `DN_STEP`=2 at one tick per cycle, a repeating 2-high/1-low pattern never trips. A 3-high/1-low pattern trips in its 14th period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| on_i | input | 1 | Power device on command, synchronous to `clk_i` |
| presc_i | input | PRE_W | Tick period minus one, in clock cycles |
| trip_o | output | 1 | Latched over-stress trip for the relay driver |
| zero_o | output | 1 | Count is zero |
| count_o | output | CNT_W | Current stress count |

## Verification
The hardest situation to reach is the prescaler phase restart. It only shows once the guard has drained to zero partway through a prescale period, sat idle, and then seen a new rising edge. The stimulus uses a prescale of 3 and times the low interval so that the count reaches zero exactly on a tick. It then holds `on_i` low for two extra cycles before raising it. The count must stay at zero for three edges and step on the fourth, which is the step an unheld prescaler would put two edges earlier. The duty-limit trip is reached by repeating a 3-high/1-low pattern until the count creeps up to its ceiling in the fourteenth period.

// File: rtl/pg_pkg.sv
package pg_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } pg_dir_e;

endpackage

// File: rtl/pg_rst_sync.sv
module pg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/pg_prescaler.sv
module pg_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic             tick_o
);

  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] div_d;
  logic             wrap;

  always_comb begin
    wrap  = (div_q >= presc_i);
    div_d = div_q;
    if (!run_i) begin
      div_d = '0;
    end else if (wrap) begin
      div_d = '0;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

  assign tick_o = run_i & wrap;

endmodule

// File: rtl/pg_arm_ctl.sv
module pg_arm_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  input  logic drained_i,
  output logic run_o
);

  logic on_q;
  logic armed_q;
  logic armed_d;
  logic rise;

  always_comb begin
    rise    = on_i & ~on_q;
    armed_d = armed_q;
    if (rise) begin
      armed_d = 1'b1;
    end else if (drained_i) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      on_q    <= on_i;
      armed_q <= armed_d;
    end
  end

  assign run_o = armed_q | rise;

endmodule

// File: rtl/pg_sat_counter.sv
module pg_sat_counter
  import pg_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int UP_STEP = 1,
  parameter int DN_STEP = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  pg_dir_e          dir_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             drained_o
);

  localparam logic [CNT_W:0] MAX_EXT = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W:0] UP_EXT  = (CNT_W+1)'(UP_STEP);
  localparam logic [CNT_W:0] DN_EXT  = (CNT_W+1)'(DN_STEP);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   cnt_ext;
  logic [CNT_W:0]   up_sum;
  logic [CNT_W:0]   dn_diff;
  logic             up_over;
  logic             dn_under;

  always_comb begin
    cnt_ext   = {1'b0, cnt_q};
    up_sum    = cnt_ext + UP_EXT;
    dn_diff   = cnt_ext - DN_EXT;
    up_over   = (up_sum > MAX_EXT);
    dn_under  = (cnt_ext <= DN_EXT);
    cnt_d     = cnt_q;
    ovf_o     = 1'b0;
    drained_o = 1'b0;
    if (tick_i) begin
      if (dir_i == DIR_UP) begin
        if (up_over) begin
          cnt_d = MAX_EXT[CNT_W-1:0];
          ovf_o = 1'b1;
        end else begin
          cnt_d = up_sum[CNT_W-1:0];
        end
      end else begin
        if (dn_under) begin
          cnt_d     = '0;
          drained_o = 1'b1;
        end else begin
          cnt_d = dn_diff[CNT_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
  import pg_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int PRE_W      = 8,
  parameter int UP_STEP    = 1,
  parameter int DN_STEP    = 1,
  parameter int RST_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             on_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic             trip_o,
  output logic             zero_o,
  output logic [CNT_W-1:0] count_o
);

  logic    rst_core_n;
  logic    run;
  logic    tick;
  logic    ovf;
  logic    drained;
  logic    trip_q;
  logic    trip_d;
  pg_dir_e dir;

  pg_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_core_n)
  );

  pg_arm_ctl u_arm_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_core_n),
    .on_i      (on_i),
    .drained_i (drained),
    .run_o     (run)
  );

  pg_prescaler #(
    .PRE_W (PRE_W)
  ) u_prescaler (
    .clk_i   (clk_i),
    .rst_ni  (rst_core_n),
    .run_i   (run),
    .presc_i (presc_i),
    .tick_o  (tick)
  );

  always_comb begin
    dir = on_i ? DIR_UP : DIR_DOWN;
  end

  pg_sat_counter #(
    .CNT_W   (CNT_W),
    .UP_STEP (UP_STEP),
    .DN_STEP (DN_STEP)
  ) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_core_n),
    .tick_i    (tick),
    .dir_i     (dir),
    .count_o   (count_o),
    .ovf_o     (ovf),
    .drained_o (drained)
  );

  always_comb begin
    trip_d = trip_q | ovf;
  end

  always_ff @(posedge clk_i or negedge rst_core_n) begin
    if (!rst_core_n) begin
      trip_q <= 1'b0;
    end else begin
      trip_q <= trip_d;
    end
  end

  assign trip_o = trip_q;
  assign zero_o = (count_o == '0);

endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             on_i,
  input logic             trip_o,
  input logic             zero_o,
  input logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R2: the count never falls while the control is high
  p_up_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_i |=> (count_o >= $past(count_o)));

  // R3: the count never rises while the control is low
  p_down_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on_i |=> (count_o <= $past(count_o)));

  // R4: a full counter driven up stays full
  p_no_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_i && count_o == CNT_MAX) |=> (count_o == CNT_MAX));

  // R5: trip latches until reset
  p_trip_latch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o |=> trip_o);

  // R5: trip only comes from an up step
  p_trip_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_o) |-> $past(on_i));

  // R8: an empty counter with the control low stays empty
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !on_i) |=> zero_o);

endmodule

bind pwr_guard pwr_guard_chk #(
  .CNT_W (CNT_W)
) u_pwr_guard_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .on_i    (on_i),
  .trip_o  (trip_o),
  .zero_o  (zero_o),
  .count_o (count_o)
);

// File: tb/test_pwr_guard.sv
module test_pwr_guard;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;
  localparam int PRE_W      = 4;

  typedef struct packed {
    logic       on;
    logic [7:0] cycles;
    logic [3:0] cnt;
    logic       zero;
    logic       trip;
  } vec_t;

  // presc 0, UP_STEP 1, DN_STEP 2, ceiling 15
  localparam vec_t VECS [12] = '{
    '{1'b0, 8'd3,  4'd0,  1'b1, 1'b0},  // R8 idle stays empty
    '{1'b1, 8'd5,  4'd5,  1'b0, 1'b0},  // R2 up by 1 from the rise edge
    '{1'b0, 8'd2,  4'd1,  1'b0, 1'b0},  // R3 down by 2
    '{1'b0, 8'd1,  4'd0,  1'b1, 1'b0},  // R3 floor at 0
    '{1'b0, 8'd2,  4'd0,  1'b1, 1'b0},  // R8 held
    '{1'b1, 8'd2,  4'd2,  1'b0, 1'b0},  // R8 rise rearms
    '{1'b0, 8'd1,  4'd0,  1'b1, 1'b0},  // R6 zero flag
    '{1'b1, 8'd12, 4'd12, 1'b0, 1'b0},  // R2 long on
    '{1'b1, 8'd3,  4'd15, 1'b0, 1'b0},  // R4 reaches ceiling
    '{1'b1, 8'd1,  4'd15, 1'b0, 1'b1},  // R5 overflow trips
    '{1'b1, 8'd2,  4'd15, 1'b0, 1'b1},  // R4 no wrap
    '{1'b0, 8'd3,  4'd9,  1'b0, 1'b1}   // R5 trip latched
  };

  logic             clk;
  logic             rst_n;
  logic             on;
  logic [PRE_W-1:0] presc;
  logic             trip;
  logic             zero;
  logic [CNT_W-1:0] count;

  int checks;
  int errors;
  bit done;

  pwr_guard #(
    .CNT_W   (CNT_W),
    .PRE_W   (PRE_W),
    .UP_STEP (1),
    .DN_STEP (2)
  ) i_pwr_guard (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .on_i    (on),
    .presc_i (presc),
    .trip_o  (trip),
    .zero_o  (zero),
    .count_o (count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input int c, input int z, input int t);
    check({tag, " count"}, int'(count), c);
    check({tag, " zero R6"}, int'(zero), z);
    check({tag, " trip"}, int'(trip), t);
  endtask

  task automatic hold(input logic val, input int n);
    on = val;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    on    = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_all("R1 reset", 0, 1, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 after release", 0, 1, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    presc  = '0;
    on     = 1'b0;
    rst_n  = 1'b0;
    @(negedge clk);
    do_reset();

    for (int i = 0; i < 12; i++) begin
      hold(VECS[i].on, int'(VECS[i].cycles));
      check_all($sformatf("table row %0d", i), int'(VECS[i].cnt),
                int'(VECS[i].zero), int'(VECS[i].trip));
    end

    // R5: reset clears the latched trip
    do_reset();

    // R7: prescale 3, one step per 4 edges
    presc = 4'd3;
    hold(1'b1, 7);
    check_all("R7 before 4th tick edge", 1, 0, 0);
    hold(1'b1, 1);
    check_all("R7 second tick", 2, 0, 0);
    hold(1'b0, 4);
    check_all("R7 down tick drains", 0, 1, 0);
    // R8: idle then rise restarts the prescaler phase
    hold(1'b0, 2);
    hold(1'b1, 3);
    check_all("R8 phase restarted, no step yet", 0, 1, 0);
    hold(1'b1, 1);
    check_all("R8 first step after rise", 1, 0, 0);

    // R9: duty limit
    do_reset();
    presc = '0;
    for (int p = 0; p < 20; p++) begin
      hold(1'b1, 2);
      hold(1'b0, 1);
    end
    check_all("R9 2:1 pattern at limit", 0, 1, 0);
    for (int p = 0; p < 13; p++) begin
      hold(1'b1, 3);
      hold(1'b0, 1);
    end
    check_all("R9 3:1 after 13 periods", 13, 0, 0);
    hold(1'b1, 3);
    hold(1'b0, 1);
    check_all("R9 3:1 trips in period 14", 13, 0, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule